// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Serializer

This block drives the data line of a two-channel serial audio transmitter. Bit timing and word-select timing come from outside. The block runs on the system clock. A one-cycle `bit_tick` strobe marks each falling edge of the bit clock. `ws` gives the channel of the bit slot that begins at that tick: 0 is left and 1 is right. A fall of `ws` starts a new frame.

Sample pairs arrive on a valid/ready port that holds one pair. `s_ready` is high while the holding slot is empty. A pair transfers on any clock where `s_valid` and `s_ready` are both high. A producer that sees `s_ready` low must keep `s_valid` and the data steady until the transfer. The held pair moves into the shift stage at the next frame start. If the holding slot is empty at that point, the frame carries zeros and `underflow` pulses.

Three alignments are supported, and data resolution can be set. A packing option splits one 32-bit word into two 16-bit samples, one per channel. Configuration inputs are treated as quasi-static.

Top module: `stereo_tx_serializer`

## Requirements
- R1: After reset `sd` is 0, `underflow` is 0 and `s_ready` is 1.
- R2: Alignment code 3'b001 (standard) places the sample MSB in slot 1 of each half-frame. Slot 0 is the first tick after a `ws` change. Bits follow MSB first, one per slot.
- R3: Alignment code 3'b100 (left-justified) places the MSB in slot 0 of each half-frame.
- R4: Alignment code 3'b010 (right-justified) places the LSB in the last slot of the half-frame, and the leading slots carry 0.
- R5: Resolution codes 1, 2, 3, 4 and 5 give sample widths of 12, 16, 20, 24 and 32 bits. Codes 0, 6 and 7 give 32 bits. The sample is right-aligned in its input word, and every slot outside the sample's bits carries 0.
- R6: Half-frame codes 0, 1 and 2 give 16, 24 and 32 slots, and code 3 gives 32. When the sample is wider than the half-frame, standard and left-justified keep the MSBs and right-justified keeps the LSBs.
- R7: With `pack_en` high, `s_left[15:0]` is the 16-bit left sample and `s_left[31:16]` is the 16-bit right sample. The resolution code and `s_right` are ignored.
- R8: Data is driven only while `blk_en` and `ch_en` are both high. Otherwise `sd` is 0, no pair is consumed and `underflow` stays low.
- R9: `s_ready` is high exactly while the holding slot is empty. A transfer fills the slot. The slot empties at a tick where `ws` falls while the block is enabled.
- R10: At an enabled frame start with the holding slot empty, the whole frame carries 0 and `underflow` is high for exactly one cycle.
- R11: An alignment code that is not one-hot drives `sd` to 0.
- R12: `sd` changes only on a clock edge where `bit_tick` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en | input | 1 | Transmitter block enable |
| ch_en | input | 1 | Channel transmit enable |
| align_mode | input | 3 | One-hot alignment: 001 standard, 010 right, 100 left |
| res_code | input | 3 | Sample resolution code |
| half_code | input | 2 | Slots per half-frame code |
| pack_en | input | 1 | Split one 32-bit word into two 16-bit samples |
| bit_tick | input | 1 | Falling bit-clock edge strobe |
| ws | input | 1 | Word select for the slot starting at this tick |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding slot empty |
| s_left | input | 32 | Left sample, or packed word |
| s_right | input | 32 | Right sample |
| sd | output | 1 | Serial data |
| underflow | output | 1 | One-cycle pulse on an empty frame start |

## Verification
All three outputs are registered, so each result is due one clock after its cause:
- The `sd` value for a slot appears after the edge that samples that slot's tick.
- `underflow` rises after the frame-start edge and falls after the next edge.
- `s_ready` falls after the transfer edge and rises after the consuming edge.

A behavioural model in the bench updates on the same rising edge from the same inputs. The bench compares it with the design at every falling edge and drives new inputs only after that comparison, so each expected value is checked in the very cycle it is due.

// File: rtl/satx_pkg.sv
package satx_pkg;
  typedef enum logic [1:0] {
    FMT_OFF   = 2'd0,
    FMT_STD   = 2'd1,
    FMT_LEFT  = 2'd2,
    FMT_RIGHT = 2'd3
  } satx_fmt_e;

  localparam logic [2:0] ALIGN_STD   = 3'b001;
  localparam logic [2:0] ALIGN_RIGHT = 3'b010;
  localparam logic [2:0] ALIGN_LEFT  = 3'b100;
endpackage

// File: rtl/satx_cfg_decode.sv
module satx_cfg_decode
  import satx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SLOT_W = 6
) (
  input  logic [2:0]        align_mode,
  input  logic [2:0]        res_code,
  input  logic [1:0]        half_code,
  input  logic              pack_en,
  output satx_fmt_e         fmt,
  output logic [SLOT_W-1:0] word_w,
  output logic [SLOT_W-1:0] half_len,
  output logic [SLOT_W-1:0] eff_w
);
  localparam logic [SLOT_W-1:0] FULL_W = SLOT_W'(DATA_W);
  localparam logic [SLOT_W-1:0] PACK_W = SLOT_W'(DATA_W / 2);

  always_comb begin
    unique case (align_mode)
      ALIGN_STD:   fmt = FMT_STD;
      ALIGN_LEFT:  fmt = FMT_LEFT;
      ALIGN_RIGHT: fmt = FMT_RIGHT;
      default:     fmt = FMT_OFF;
    endcase
  end

  always_comb begin
    if (pack_en) begin
      word_w = PACK_W;
    end else begin
      unique case (res_code)
        3'd1, 3'd2, 3'd3, 3'd4: word_w = SLOT_W'(8 + 4 * int'(res_code));
        default:                word_w = FULL_W;
      endcase
    end
    if (word_w > FULL_W) word_w = FULL_W;
  end

  always_comb begin
    unique case (half_code)
      2'd0, 2'd1, 2'd2: half_len = SLOT_W'(16 + 8 * int'(half_code));
      default:          half_len = SLOT_W'(32);
    endcase
  end

  assign eff_w = (word_w < half_len) ? word_w : half_len;
endmodule

// File: rtl/satx_slot_track.sv
module satx_slot_track #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              ws,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              frame_start
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic              ws_q;
  logic [SLOT_W-1:0] slot_q;
  logic              half_start;

  assign half_start  = bit_tick && (ws != ws_q);
  assign frame_start = bit_tick && ws_q && !ws;

  always_comb begin
    if (half_start)             slot_nxt = '0;
    else if (slot_q != SLOT_MAX) slot_nxt = slot_q + 1'b1;
    else                         slot_nxt = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q   <= 1'b1;
      slot_q <= SLOT_MAX;
    end else if (bit_tick) begin
      ws_q   <= ws;
      slot_q <= slot_nxt;
    end
  end
endmodule

// File: rtl/satx_sample_hold.sv
module satx_sample_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_left,
  input  logic [DATA_W-1:0] s_right,
  input  logic              pack_en,
  input  logic              load,
  input  logic              chan,
  output logic [DATA_W-1:0] word,
  output logic              underflow
);
  localparam int HALF_W = DATA_W / 2;

  logic              pend_full;
  logic [DATA_W-1:0] pend_l, pend_r;
  logic [DATA_W-1:0] act_l, act_r;
  logic [DATA_W-1:0] conv_l, conv_r;
  logic [DATA_W-1:0] src_l, src_r;

  assign s_ready = !pend_full;

  always_comb begin
    if (pack_en) begin
      conv_l = {{(DATA_W-HALF_W){1'b0}}, pend_l[HALF_W-1:0]};
      conv_r = {{(DATA_W-HALF_W){1'b0}}, pend_l[DATA_W-1:HALF_W]};
    end else begin
      conv_l = pend_l;
      conv_r = pend_r;
    end
  end

  always_comb begin
    if (load) begin
      src_l = pend_full ? conv_l : '0;
      src_r = pend_full ? conv_r : '0;
    end else begin
      src_l = act_l;
      src_r = act_r;
    end
  end

  assign word = chan ? src_r : src_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_l    <= '0;
      pend_r    <= '0;
      act_l     <= '0;
      act_r     <= '0;
      underflow <= 1'b0;
    end else begin
      underflow <= load && !pend_full;
      if (load) begin
        act_l <= src_l;
        act_r <= src_r;
      end
      if (s_valid && s_ready) begin
        pend_full <= 1'b1;
        pend_l    <= s_left;
        pend_r    <= s_right;
      end else if (load && pend_full) begin
        pend_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stereo_tx_serializer.sv
module stereo_tx_serializer
  import satx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  logic              ch_en,
  input  logic [2:0]        align_mode,
  input  logic [2:0]        res_code,
  input  logic [1:0]        half_code,
  input  logic              pack_en,
  input  logic              bit_tick,
  input  logic              ws,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_left,
  input  logic [DATA_W-1:0] s_right,
  output logic              sd,
  output logic              underflow
);
  localparam int SLOT_W = $clog2(DATA_W) + 1;

  satx_fmt_e         fmt;
  logic [SLOT_W-1:0] word_w, half_len, eff_w;
  logic [SLOT_W-1:0] slot;
  logic              frame_start;
  logic              enabled;
  logic              load;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] shifted;
  logic [SLOT_W-1:0] sh;
  logic              hit;
  logic              bit_val;

  assign enabled = blk_en && ch_en;
  assign load    = frame_start && enabled;

  satx_cfg_decode #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) i_cfg (
    .align_mode (align_mode),
    .res_code   (res_code),
    .half_code  (half_code),
    .pack_en    (pack_en),
    .fmt        (fmt),
    .word_w     (word_w),
    .half_len   (half_len),
    .eff_w      (eff_w)
  );

  satx_slot_track #(.SLOT_W(SLOT_W)) i_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .ws          (ws),
    .slot_nxt    (slot),
    .frame_start (frame_start)
  );

  satx_sample_hold #(.DATA_W(DATA_W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_left    (s_left),
    .s_right   (s_right),
    .pack_en   (pack_en),
    .load      (load),
    .chan      (ws),
    .word      (word),
    .underflow (underflow)
  );

  always_comb begin
    hit = 1'b0;
    sh  = '0;
    unique case (fmt)
      FMT_STD: begin
        hit = (slot != '0) && (slot <= eff_w) && (slot < half_len);
        sh  = word_w - slot;
      end
      FMT_LEFT: begin
        hit = slot < eff_w;
        sh  = word_w - slot - 1'b1;
      end
      FMT_RIGHT: begin
        hit = (slot < half_len) && (slot >= half_len - eff_w);
        sh  = half_len - slot - 1'b1;
      end
      default: begin
        hit = 1'b0;
        sh  = '0;
      end
    endcase
  end

  assign shifted = word >> sh;
  assign bit_val = hit && shifted[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd <= 1'b0;
    else if (bit_tick) sd <= enabled ? bit_val : 1'b0;
  end
endmodule

// File: rtl/satx_checks.sv
module satx_checks #(
  parameter int DATA_W = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       blk_en,
  input logic       ch_en,
  input logic [2:0] align_mode,
  input logic       bit_tick,
  input logic       s_valid,
  input logic       s_ready,
  input logic       sd,
  input logic       underflow
);
  // R12: the line only moves after a sampled tick
  a_r12_sd_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(sd));

  // R10: the underflow pulse lasts a single cycle
  a_r10_uflow_single: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow);

  // R10: underflow follows a tick
  a_r10_uflow_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(bit_tick));

  // R9: a transfer fills the holding slot
  a_r9_ready_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R8: disabled ticks drive zero
  a_r8_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_tick) && !$past(blk_en && ch_en)) |-> !sd);

  // R11: a non one-hot alignment drives zero
  a_r11_bad_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_tick) && ($countones($past(align_mode)) != 1)) |-> !sd);
endmodule

bind stereo_tx_serializer satx_checks #(.DATA_W(DATA_W)) i_satx_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .blk_en     (blk_en),
  .ch_en      (ch_en),
  .align_mode (align_mode),
  .bit_tick   (bit_tick),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .sd         (sd),
  .underflow  (underflow)
);

// File: tb/test_stereo_tx_serializer.sv
module test_stereo_tx_serializer;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          blk_en = 1'b0, ch_en = 1'b0;
  logic [2:0]    align_mode = 3'b001, res_code = 3'd0;
  logic [1:0]    half_code = 2'd2;
  logic          pack_en = 1'b0;
  logic          bit_tick = 1'b0, ws = 1'b1;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_left = '0, s_right = '0;
  logic          sd, underflow;

  stereo_tx_serializer #(.DATA_W(DW)) i_stereo_tx_serializer (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .ch_en(ch_en),
    .align_mode(align_mode), .res_code(res_code), .half_code(half_code),
    .pack_en(pack_en), .bit_tick(bit_tick), .ws(ws), .s_valid(s_valid),
    .s_ready(s_ready), .s_left(s_left), .s_right(s_right), .sd(sd),
    .underflow(underflow)
  );

  int    vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  bit            m_prev_ws = 1'b1;
  int            m_slot = 63;
  logic [DW-1:0] qa[$], qb[$];
  logic [DW-1:0] act_a = '0, act_b = '0;
  logic          exp_sd = 1'b0, exp_uf = 1'b0, exp_rdy = 1'b1;
  bit            took = 1'b0;

  function automatic int width_of(logic [2:0] rc, logic pk);
    if (pk) return 16;
    case (rc)
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int half_of(logic [1:0] hc);
    case (hc)
      2'd0: return 16;
      2'd1: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic ref_bit(logic [DW-1:0] w, int s, logic [2:0] am,
                                   logic [2:0] rc, logic [1:0] hc, logic pk);
    int wd, h, e, first, idx;
    wd = width_of(rc, pk);
    h  = half_of(hc);
    e  = (wd < h) ? wd : h;
    if (am == 3'b001) first = 1;
    else if (am == 3'b100) first = 0;
    else if (am == 3'b010) first = h - e;
    else return 1'b0;
    if (s < first || s >= first + e || s >= h) return 1'b0;
    idx = (am == 3'b010) ? (e - 1 - (s - first)) : (wd - 1 - (s - first));
    return w[idx];
  endfunction

  always @(posedge clk) begin
    bit hs, fs, en;
    logic [DW-1:0] wa, wb;
    if (!rst_n) begin
      m_prev_ws = 1'b1; m_slot = 63; qa.delete(); qb.delete();
      act_a = '0; act_b = '0; exp_sd = 1'b0; exp_uf = 1'b0; exp_rdy = 1'b1; took = 1'b0;
    end else begin
      hs = s_valid && exp_rdy;
      took = hs;
      exp_uf = 1'b0;
      if (bit_tick) begin
        fs = m_prev_ws && !ws;
        if (ws != m_prev_ws) m_slot = 0;
        else if (m_slot < 63) m_slot++;
        m_prev_ws = ws;
        en = blk_en && ch_en;
        if (fs && en) begin
          if (qa.size() > 0) begin
            wa = qa.pop_front(); wb = qb.pop_front();
            if (pack_en) begin act_a = {16'h0, wa[15:0]}; act_b = {16'h0, wa[31:16]}; end
            else begin act_a = wa; act_b = wb; end
          end else begin
            act_a = '0; act_b = '0; exp_uf = 1'b1;
          end
        end
        exp_sd = en ? ref_bit(ws ? act_b : act_a, m_slot, align_mode, res_code, half_code, pack_en) : 1'b0;
      end
      if (hs) begin qa.push_back(s_left); qb.push_back(s_right); end
      exp_rdy = (qa.size() == 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(logic act, logic exp, string req, string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  // bench-side drivers
  int      div = 2, div_cnt = 0, bslot = 0;
  bit      chan = 1'b1, feed = 1'b1;
  logic [31:0] seed = 32'h1d2c_3b4a;

  function automatic logic [31:0] next_rand(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic step();
    @(negedge clk);
    chk(sd, exp_sd, cur_req, "sd");
    chk(underflow, exp_uf, "R10", "underflow");
    chk(s_ready, exp_rdy, "R9", "s_ready");
    if (took) s_valid = 1'b0;
    if (feed && !s_valid) begin
      seed = next_rand(seed); s_left = seed;
      seed = next_rand(seed); s_right = seed;
      s_valid = 1'b1;
    end
    if (div_cnt == 0) begin
      bit_tick = 1'b1;
      if (bslot == 0) chan = !chan;
      ws = chan;
      bslot++;
      if (bslot >= half_of(half_code)) bslot = 0;
    end else begin
      bit_tick = 1'b0;
    end
    div_cnt = (div_cnt + 1) % div;
  endtask

  task automatic run_frames(int n);
    int target;
    target = n * 2 * half_of(half_code) * div;
    for (int i = 0; i < target; i++) step();
  endtask

  task automatic cfg(string req, logic [2:0] am, logic [2:0] rc, logic [1:0] hc, logic pk);
    cur_req = req; align_mode = am; res_code = rc; half_code = hc; pack_en = pk;
    bslot = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sd, 1'b0, "R1", "sd in reset");
    chk(underflow, 1'b0, "R1", "underflow in reset");
    chk(s_ready, 1'b1, "R1", "s_ready in reset");
    rst_n = 1'b1;
    blk_en = 1'b1; ch_en = 1'b1;
    @(negedge clk);
    chk(s_ready, 1'b1, "R1", "s_ready after reset");

    cfg("R2", 3'b001, 3'd2, 2'd2, 1'b0); run_frames(4);
    cfg("R3", 3'b100, 3'd4, 2'd2, 1'b0); run_frames(4);
    cfg("R4", 3'b010, 3'd3, 2'd1, 1'b0); run_frames(4);
    cfg("R5", 3'b001, 3'd1, 2'd0, 1'b0); run_frames(3);
    cfg("R5", 3'b100, 3'd0, 2'd2, 1'b0); run_frames(3);
    cfg("R5", 3'b010, 3'd7, 2'd2, 1'b0); run_frames(3);
    cfg("R6", 3'b010, 3'd5, 2'd3, 1'b0); run_frames(3);
    cfg("R6", 3'b100, 3'd4, 2'd0, 1'b0); run_frames(3);
    cfg("R6", 3'b010, 3'd4, 2'd0, 1'b0); run_frames(3);
    cfg("R6", 3'b001, 3'd5, 2'd0, 1'b0); run_frames(3);
    cfg("R7", 3'b001, 3'd1, 2'd2, 1'b1); run_frames(4);
    cfg("R7", 3'b010, 3'd5, 2'd1, 1'b1); run_frames(3);
    cfg("R8", 3'b001, 3'd2, 2'd2, 1'b0);
    blk_en = 1'b0; run_frames(2);
    blk_en = 1'b1; ch_en = 1'b0; run_frames(2);
    ch_en = 1'b1; run_frames(2);
    cfg("R10", 3'b100, 3'd2, 2'd0, 1'b0);
    feed = 1'b0; run_frames(4);
    feed = 1'b1; run_frames(2);
    cfg("R11", 3'b011, 3'd2, 2'd2, 1'b0); run_frames(2);
    cfg("R11", 3'b000, 3'd2, 2'd2, 1'b0); run_frames(2);
    div = 3; div_cnt = 0;
    cfg("R12", 3'b001, 3'd4, 2'd2, 1'b0); run_frames(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule